// File: doc/BRIEF.md
# Bulk Receive Frame Deaggregator

This block takes apart one bulk-in transfer that carries several Ethernet frames packed end to end. The source first announces the transfer with a start strobe and its byte count. It then streams the bytes one per beat over a valid/ready input. A 4-byte status word comes ahead of every frame. The block reads the frame length and the error flag from that word and checks them against the bytes still to come. It then passes the frame payload out on a valid/ready byte port, with a start marker on the first byte and an end marker on the last. The 4-byte trailing checksum of every frame is swallowed and not sent on.

After each frame the block skips the filler bytes up to the next 4-byte boundary. The boundary is counted from the first byte of the transfer. When the byte count runs out exactly at a frame boundary, the block raises a one-cycle done pulse. Any header fault or length fault raises a one-cycle error pulse with a code. The block then consumes and discards the rest of the transfer, so the source can always finish its stream, and returns to idle.

Top module: `rx_frame_deagg`

## Requirements
- R1: A status word is taken from four consecutive bytes, least significant byte first. The frame length is its bits 29:16 and bit 15 is the error flag. All other bits have no effect on the output.
- R2: For a frame of length L, exactly L-4 payload bytes go out in stream order. out_sof is set on the first of them and out_eof on the last. The last 4 bytes of the frame are discarded.
- R3: After a frame, bytes are skipped until the offset from the start of the transfer is a multiple of 4. If fewer bytes remain than that filler needs, they are skipped and the transfer ends cleanly.
- R4: When the remaining count is zero where a status word would begin, done pulses for one cycle and err_valid stays low. This includes a transfer of length 0.
- R5: A status word with bit 15 set ends the transfer with err_code 2, whatever its length field holds. err_valid pulses once with a nonzero code, and never in the same cycle as done.
- R6: When 1 to 3 bytes remain where a status word would begin, the transfer ends with err_code 1.
- R7: A length larger than the bytes left after the status word ends the transfer with err_code 3. A length equal to the bytes left is accepted.
- R8: A length below 5 ends the transfer with err_code 5. This check takes precedence over the R7 check.
- R9: A transfer length above 2048 is rejected with err_code 4 when the start strobe is accepted, and no byte is forwarded. A length of exactly 2048 is accepted.
- R10: After an error, the rest of the announced bytes are accepted and dropped, with no further output. The next transfer is then handled normally.
- R11: While out_valid is high and out_ready is low, the output beat holds steady and input payload is stalled, so no byte is lost or repeated.
- R12: start_ready is high only when idle. In that state in_ready stays low, and the cycle after a start strobe is accepted start_ready is low.
- R13: After reset, out_valid, done and err_valid are low, start_ready is high and in_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start | input | 1 | Announces a new transfer |
| xfer_len | input | 12 | Byte count of the announced transfer |
| start_ready | output | 1 | High when a start strobe is accepted |
| in_data | input | 8 | Transfer byte |
| in_valid | input | 1 | in_data is valid |
| in_ready | output | 1 | Block takes in_data this cycle |
| out_data | output | 8 | Payload byte |
| out_sof | output | 1 | First payload byte of a frame |
| out_eof | output | 1 | Last payload byte of a frame |
| out_valid | output | 1 | Output beat is valid |
| out_ready | input | 1 | Sink takes the output beat |
| done | output | 1 | One-cycle pulse on a clean end of transfer |
| err_valid | output | 1 | One-cycle pulse on an aborted transfer |
| err_code | output | 3 | Cause: 1 short header, 2 error flag, 3 oversize, 4 transfer too long, 5 runt length |

## Verification
A wrong remaining count or alignment offset makes the next status word come from the wrong bytes. That shows up within one frame as a wrong payload byte, a wrong marker, or a false error code. A wrong payload counter moves out_eof and shifts every later frame. A wrong drain count makes the block either stall the source or return to idle too early, and the bench sees either one before its next transfer. Payload bytes are compared one by one against a parser model, with the input and output both throttled, so any dropped or repeated beat breaks the comparison at that byte.

// File: rtl/dagg_pkg.sv
package dagg_pkg;

  typedef enum logic [2:0] {
    ERR_NONE      = 3'd0,
    ERR_SHORT_HDR = 3'd1,
    ERR_STATUS    = 3'd2,
    ERR_OVERSIZE  = 3'd3,
    ERR_TOO_LONG  = 3'd4,
    ERR_RUNT      = 3'd5
  } dagg_err_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BOUND,
    ST_HDR,
    ST_EVAL,
    ST_PAY,
    ST_FCS,
    ST_PAD,
    ST_DRAIN
  } dagg_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       sof;
    logic       eof;
  } dagg_beat_t;

endpackage

// File: rtl/dagg_xfer_cnt.sv
module dagg_xfer_cnt #(
  parameter int REM_W = 12,
  parameter int ALIGN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [REM_W-1:0] load_val,
  input  logic             step,
  output logic [REM_W-1:0] rem,
  output logic [$clog2(ALIGN)-1:0] off
);
  localparam int OFF_W = $clog2(ALIGN);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem <= '0;
      off <= '0;
    end else if (load) begin
      rem <= load_val;
      off <= '0;
    end else if (step) begin
      rem <= rem - REM_W'(1);
      off <= off + OFF_W'(1);
    end
  end
endmodule

// File: rtl/dagg_hdr_check.sv
module dagg_hdr_check
  import dagg_pkg::*;
#(
  parameter int HDR_W    = 32,
  parameter int FLEN_LSB = 16,
  parameter int FLEN_W   = 14,
  parameter int ES_BIT   = 15,
  parameter int TRAIL    = 4,
  parameter int REM_W    = 12
) (
  input  logic [HDR_W-1:0]  hdr,
  input  logic [REM_W-1:0]  rem,
  output dagg_err_e         err,
  output logic [FLEN_W-1:0] pay_len
);
  localparam int CMP_W = (FLEN_W > REM_W) ? FLEN_W : REM_W;

  logic [FLEN_W-1:0] flen;
  logic [CMP_W-1:0]  flen_x;
  logic [CMP_W-1:0]  rem_x;

  assign flen   = hdr[FLEN_LSB +: FLEN_W];
  assign flen_x = CMP_W'(flen);
  assign rem_x  = CMP_W'(rem);

  // Priority: error flag, then runt length, then overrun of the remainder
  always_comb begin
    err = ERR_NONE;
    if (hdr[ES_BIT])
      err = ERR_STATUS;
    else if (flen_x < CMP_W'(TRAIL + 1))
      err = ERR_RUNT;
    else if (flen_x > rem_x)
      err = ERR_OVERSIZE;
  end

  assign pay_len = flen - FLEN_W'(TRAIL);
endmodule

// File: rtl/dagg_out_stage.sv
module dagg_out_stage
  import dagg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       push,
  input  dagg_beat_t beat_in,
  input  logic       out_ready,
  output logic       out_valid,
  output dagg_beat_t beat_q,
  output logic       can_accept
);
  assign can_accept = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      beat_q    <= '0;
    end else begin
      if (push) begin
        out_valid <= 1'b1;
        beat_q    <= beat_in;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rx_frame_deagg.sv
module rx_frame_deagg
  import dagg_pkg::*;
#(
  parameter int MAX_XFER    = 2048,
  parameter int LEN_W       = $clog2(MAX_XFER) + 1,
  parameter int HDR_BYTES   = 4,
  parameter int TRAIL_BYTES = 4,
  parameter int ALIGN       = 4,
  parameter int FLEN_LSB    = 16,
  parameter int FLEN_W      = 14,
  parameter int ES_BIT      = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xfer_start,
  input  logic [LEN_W-1:0] xfer_len,
  output logic             start_ready,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [7:0]       out_data,
  output logic             out_sof,
  output logic             out_eof,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             done,
  output logic             err_valid,
  output logic [2:0]       err_code
);
  localparam int HDR_W  = 8 * HDR_BYTES;
  localparam int CNT_N  = (HDR_BYTES > TRAIL_BYTES) ? HDR_BYTES : TRAIL_BYTES;
  localparam int CNT_W  = $clog2(CNT_N);
  localparam int OFF_W  = $clog2(ALIGN);

  dagg_state_e       state;
  logic [HDR_W-1:0]  hdr;
  logic [CNT_W-1:0]  bcnt;
  logic [FLEN_W-1:0] pcnt;
  logic              first;
  dagg_err_e         err_q;

  logic [LEN_W-1:0]  rem;
  logic [OFF_W-1:0]  off;
  logic              beat;
  logic              cnt_load;

  dagg_err_e         chk_err;
  logic [FLEN_W-1:0] chk_pay;

  logic              push;
  dagg_beat_t        push_beat;
  dagg_beat_t        out_beat;
  logic              can_accept;

  assign start_ready = (state == ST_IDLE);
  assign cnt_load    = (state == ST_IDLE) && xfer_start;
  assign beat        = in_valid && in_ready;

  always_comb begin
    in_ready = 1'b0;
    case (state)
      ST_HDR, ST_FCS: in_ready = 1'b1;
      ST_PAY:         in_ready = can_accept;
      ST_PAD:         in_ready = (off != '0) && (rem != '0);
      ST_DRAIN:       in_ready = (rem != '0);
      default:        in_ready = 1'b0;
    endcase
  end

  dagg_xfer_cnt #(.REM_W(LEN_W), .ALIGN(ALIGN)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (xfer_len),
    .step     (beat),
    .rem      (rem),
    .off      (off)
  );

  dagg_hdr_check #(
    .HDR_W    (HDR_W),
    .FLEN_LSB (FLEN_LSB),
    .FLEN_W   (FLEN_W),
    .ES_BIT   (ES_BIT),
    .TRAIL    (TRAIL_BYTES),
    .REM_W    (LEN_W)
  ) u_chk (
    .hdr     (hdr),
    .rem     (rem),
    .err     (chk_err),
    .pay_len (chk_pay)
  );

  assign push           = (state == ST_PAY) && beat;
  assign push_beat.data = in_data;
  assign push_beat.sof  = first;
  assign push_beat.eof  = (pcnt == FLEN_W'(1));

  dagg_out_stage u_out (
    .clk        (clk),
    .rst        (rst),
    .push       (push),
    .beat_in    (push_beat),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .beat_q     (out_beat),
    .can_accept (can_accept)
  );

  assign out_data = out_beat.data;
  assign out_sof  = out_beat.sof;
  assign out_eof  = out_beat.eof;
  assign err_code = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      hdr       <= '0;
      bcnt      <= '0;
      pcnt      <= '0;
      first     <= 1'b0;
      done      <= 1'b0;
      err_valid <= 1'b0;
      err_q     <= ERR_NONE;
    end else begin
      done      <= 1'b0;
      err_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (xfer_start) begin
            if (xfer_len > LEN_W'(MAX_XFER)) begin
              err_valid <= 1'b1;
              err_q     <= ERR_TOO_LONG;
              state     <= ST_DRAIN;
            end else begin
              state <= ST_BOUND;
            end
          end
        end
        ST_BOUND: begin
          if (rem == '0) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else if (rem < LEN_W'(HDR_BYTES)) begin
            err_valid <= 1'b1;
            err_q     <= ERR_SHORT_HDR;
            state     <= ST_DRAIN;
          end else begin
            bcnt  <= '0;
            state <= ST_HDR;
          end
        end
        ST_HDR: begin
          if (beat) begin
            hdr  <= {in_data, hdr[HDR_W-1:8]};
            bcnt <= bcnt + CNT_W'(1);
            if (bcnt == CNT_W'(HDR_BYTES - 1))
              state <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (chk_err != ERR_NONE) begin
            err_valid <= 1'b1;
            err_q     <= chk_err;
            state     <= (rem == '0) ? ST_IDLE : ST_DRAIN;
          end else begin
            pcnt  <= chk_pay;
            first <= 1'b1;
            state <= ST_PAY;
          end
        end
        ST_PAY: begin
          if (beat) begin
            first <= 1'b0;
            pcnt  <= pcnt - FLEN_W'(1);
            if (pcnt == FLEN_W'(1)) begin
              bcnt  <= '0;
              state <= ST_FCS;
            end
          end
        end
        ST_FCS: begin
          if (beat) begin
            bcnt <= bcnt + CNT_W'(1);
            if (bcnt == CNT_W'(TRAIL_BYTES - 1))
              state <= ST_PAD;
          end
        end
        ST_PAD: begin
          if ((off == '0) || (rem == '0))
            state <= ST_BOUND;
        end
        ST_DRAIN: begin
          if (rem == '0)
            state <= ST_IDLE;
          else if (beat && (rem == LEN_W'(1)))
            state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_frame_deagg_checker.sv
module rx_frame_deagg_checker (
  input logic       clk,
  input logic       rst,
  input logic       xfer_start,
  input logic       start_ready,
  input logic       in_ready,
  input logic [7:0] out_data,
  input logic       out_sof,
  input logic       out_eof,
  input logic       out_valid,
  input logic       out_ready,
  input logic       done,
  input logic       err_valid,
  input logic [2:0] err_code
);
  logic in_frame;

  always_ff @(posedge clk) begin
    if (rst)
      in_frame <= 1'b0;
    else if (out_valid && out_ready) begin
      if (out_eof)
        in_frame <= 1'b0;
      else if (out_sof)
        in_frame <= 1'b1;
    end
  end

  // R11: a stalled output beat is held unchanged
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eof));

  // R2: a start marker only opens a frame, other beats only continue one
  p_sof_open_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_sof |-> !in_frame);
  p_cont_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_sof |-> in_frame);

  // R5: outcome pulses are exclusive and errors carry a cause
  p_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(done && err_valid));
  p_code_r5: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> err_code != 3'd0);

  // R12: no input is taken while idle, and a start leaves idle
  p_idle_r12: assert property (@(posedge clk) disable iff (rst)
    start_ready |-> !in_ready);
  p_busy_r12: assert property (@(posedge clk) disable iff (rst)
    start_ready && xfer_start |=> !start_ready);
endmodule

bind rx_frame_deagg rx_frame_deagg_checker u_checker (
  .clk         (clk),
  .rst         (rst),
  .xfer_start  (xfer_start),
  .start_ready (start_ready),
  .in_ready    (in_ready),
  .out_data    (out_data),
  .out_sof     (out_sof),
  .out_eof     (out_eof),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .done        (done),
  .err_valid   (err_valid),
  .err_code    (err_code)
);

// File: tb/rx_frame_deagg_bench.sv
module rx_frame_deagg_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        xfer_start = 1'b0;
  logic [11:0] xfer_len = '0;
  logic        start_ready;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  out_data;
  logic        out_sof, out_eof, out_valid;
  logic        out_ready = 1'b1;
  logic        done, err_valid;
  logic [2:0]  err_code;

  always #10 clk = ~clk;

  rx_frame_deagg u_rx_frame_deagg (
    .clk(clk), .rst(rst), .xfer_start(xfer_start), .xfer_len(xfer_len),
    .start_ready(start_ready), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_sof(out_sof),
    .out_eof(out_eof), .out_valid(out_valid), .out_ready(out_ready),
    .done(done), .err_valid(err_valid), .err_code(err_code)
  );

  int n_chk = 0;
  int n_bad = 0;
  int stress = 0;

  logic [7:0] xbuf [0:4095];
  int xlen;
  int pat = 0;
  logic [9:0] exp_q[$];
  logic [9:0] got_q[$];
  int exp_code;
  int got_done, got_err, got_code;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(20 * 195000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk); #2;
      out_ready = (stress != 0) ? ($urandom_range(0, 2) != 0) : 1'b1;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid && out_ready) got_q.push_back({out_data, out_sof, out_eof});
      if (done) got_done++;
      if (err_valid) begin got_err++; got_code = int'(err_code); end
    end
  end

  task automatic add_byte(input logic [7:0] b);
    xbuf[xlen] = b;
    xlen++;
  endtask

  task automatic add_hdr(input int flen, input bit es, input logic [1:0] hi);
    logic [13:0] f;
    logic [31:0] w;
    f = 14'(flen);
    w = {hi, f, es, 15'h2A5C};
    for (int k = 0; k < 4; k++) add_byte(w[8*k +: 8]);
  endtask

  task automatic add_frame(input int flen, input bit es, input logic [1:0] hi);
    add_hdr(flen, es, hi);
    for (int j = 0; j < flen - 4; j++) begin add_byte(8'((pat * 7 + 3) & 255)); pat++; end
    for (int j = 0; j < 4; j++) add_byte(8'hC0 + 8'(j));
    while ((xlen % 4) != 0) add_byte(8'hEE);
  endtask

  // Parser model written from the requirements
  task automatic model();
    int pos, rem, flen, pad;
    logic [31:0] h;
    exp_q.delete();
    exp_code = 0;
    if (xlen > 2048) begin exp_code = 4; return; end
    pos = 0; rem = xlen;
    forever begin
      if (rem == 0) return;
      if (rem < 4) begin exp_code = 1; return; end
      h = {xbuf[pos+3], xbuf[pos+2], xbuf[pos+1], xbuf[pos]};
      pos += 4; rem -= 4;
      if (h[15]) begin exp_code = 2; return; end
      flen = int'(h[29:16]);
      if (flen < 5) begin exp_code = 5; return; end
      if (flen > rem) begin exp_code = 3; return; end
      for (int j = 0; j < flen - 4; j++)
        exp_q.push_back({xbuf[pos+j], (j == 0), (j == flen - 5)});
      pos += flen; rem -= flen;
      pad = (4 - (pos % 4)) % 4;
      if (pad > rem) pad = rem;
      pos += pad; rem -= pad;
    end
  endtask

  task automatic run(input string req_out, input string req_end);
    bit took;
    int n;
    model();
    got_q.delete();
    got_done = 0; got_err = 0; got_code = 0;
    @(posedge clk); #2;
    xfer_start = 1'b1;
    xfer_len = 12'(xlen);
    @(posedge clk); #2;
    xfer_start = 1'b0;
    for (int i = 0; i < xlen; i++) begin
      if (stress != 0) begin
        while ($urandom_range(0, 3) == 0) begin in_valid = 1'b0; @(posedge clk); #2; end
      end
      in_valid = 1'b1;
      in_data = xbuf[i];
      do begin @(negedge clk); took = in_ready; @(posedge clk); #2; end while (!took);
      in_valid = 1'b0;
    end
    do @(negedge clk); while (!(start_ready && !out_valid));
    repeat (2) @(negedge clk);
    chk(got_q.size() == exp_q.size(), req_out, "payload byte count", got_q.size(), exp_q.size());
    n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
    for (int i = 0; i < n; i++)
      chk(got_q[i] == exp_q[i], req_out, $sformatf("beat %0d {data,sof,eof}", i), int'(got_q[i]), int'(exp_q[i]));
    if (exp_code == 0) begin
      chk(got_done == 1 && got_err == 0, req_end, "done pulses (clean end)", got_done * 10 + got_err, 10);
    end else begin
      chk(got_err == 1 && got_done == 0, req_end, "error pulses", got_err * 10 + got_done, 10);
      chk(got_code == exp_code, req_end, "error code", got_code, exp_code);
    end
    xlen = 0;
  endtask

  initial begin
    xlen = 0;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    // R13: reset state
    chk(!out_valid && !done && !err_valid, "R13", "outputs after reset", {out_valid, done, err_valid}, 0);
    chk(start_ready == 1'b1, "R13", "start_ready after reset", start_ready, 1);
    chk(in_ready == 1'b0, "R13", "in_ready after reset", in_ready, 0);

    // R4: empty transfer ends at once
    xlen = 0; run("R4", "R4");

    // R3 / R11: sweep of two-frame transfers over every filler size
    for (int a = 5; a <= 16; a++)
      for (int b = 5; b <= 9; b++) begin
        stress = (a + b) % 2;
        add_frame(a, 0, 2'b00); add_frame(b, 0, 2'b00);
        run((stress != 0) ? "R11" : "R3", "R4");
      end
    stress = 1;

    // R1: unused header bits are ignored
    for (int h = 0; h < 4; h++) begin
      add_frame(9 + h, 0, 2'(h)); add_frame(6, 0, 2'(3 - h));
      run("R1", "R4");
    end

    // R3: filler cut short by the end of the transfer
    for (int a = 5; a <= 7; a++)
      for (int k = 1; k <= 8 - a; k++) begin
        add_frame(a, 0, 2'b00); add_frame(a, 0, 2'b01);
        xlen -= k;
        run("R3", "R3");
      end

    // R6: 1 to 3 stray bytes where a header is due
    for (int k = 1; k <= 3; k++) begin
      add_frame(8, 0, 2'b00);
      for (int j = 0; j < k; j++) add_byte(8'h11);
      run("R2", "R6");
    end

    // R5: error flag wins even with a huge length field
    add_frame(10, 0, 2'b00); add_hdr(3000, 1, 2'b00);
    for (int j = 0; j < 20; j++) add_byte(8'(j));
    run("R2", "R5");
    add_frame(7, 0, 2'b00); add_frame(12, 1, 2'b00); add_frame(6, 0, 2'b00);
    run("R2", "R5");

    // R8: runt lengths, even when also larger than the remainder
    for (int f = 0; f <= 4; f++) begin
      add_frame(6, 0, 2'b00); add_hdr(f, 0, 2'b00);
      run("R2", "R8");
    end
    add_frame(5, 0, 2'b00); add_hdr(2, 0, 2'b00);
    for (int j = 0; j < 8; j++) add_byte(8'h22);
    run("R2", "R8");

    // R7: oversize by one, and exact fit
    add_frame(6, 0, 2'b00); add_hdr(21, 0, 2'b00);
    for (int j = 0; j < 20; j++) add_byte(8'(j + 40));
    run("R2", "R7");
    add_frame(6, 0, 2'b00); add_hdr(20, 0, 2'b00);
    for (int j = 0; j < 20; j++) add_byte(8'(j + 60));
    run("R7", "R4");

    // R10: abort with many bytes left, then a normal transfer
    add_hdr(200, 0, 2'b00);
    for (int j = 0; j < 60; j++) add_byte(8'h5A);
    run("R10", "R7");
    add_frame(13, 0, 2'b00); add_frame(5, 0, 2'b00);
    run("R10", "R4");

    // R9: over-long transfer rejected, maximal one accepted
    for (int j = 0; j < 2049; j++) add_byte(8'(j));
    run("R9", "R9");
    add_frame(2044, 0, 2'b00);
    run("R9", "R4");

    // R12: bytes offered while idle are not taken
    @(posedge clk); #2;
    in_valid = 1'b1; in_data = 8'h77;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(in_ready == 1'b0 && out_valid == 1'b0, "R12", "idle input taken", {in_ready, out_valid}, 0);
      @(posedge clk); #2;
    end
    in_valid = 1'b0;
    add_frame(11, 0, 2'b10);
    run("R12", "R4");

    report();
    $finish;
  end
endmodule